// File: doc/BRIEF.md
# Page-Mode External Fetch Bus Controller

This controller runs the bus that fetches program bytes from an external memory. One 8-bit address port is shared in time between the high and the low address byte, and fetched bytes come back on a separate 8-bit data port. The controller remembers which 256-byte page is open. A fetch that stays inside it is a short cycle that drives only the low byte. A fetch that leaves it is a long cycle. That long cycle first puts the new high byte on the address port and strobes it into an external latch, then runs the same fetch phase as a short cycle.

The core hands over one request at a time through a valid/ready handshake. A request carries a 16-bit address and a flag that marks it as a stall, which is a dummy cycle with no memory read. The controller reports completion with a one-clock done pulse that carries the byte. A configuration write port sets a 2-bit page-size field and an enable bit. Page mode is only entered from code running in internal memory, and only in the order size first, enable second. While page mode is off, every fetch runs as a long cycle with the latch phase.

Top module: `pgfetch_ctrl`

## Requirements
- R1: During the latch phase of a long cycle (its first four clocks) `bus_addr` carries bits 15:8 of the request address. During the fetch phase of every cycle (the last four clocks) it carries bits 7:0.
- R2: The byte returned on `done_data` is the value of `bus_data_in` in the clock where `done` is high, and the address port is never a data source.
- R3: `ale` is high for exactly two clocks (the 2nd and 3rd) of each long cycle and is never high in a short cycle.
- R4: `psen` is high in the last three clocks of the fetch phase of each real fetch and is never high together with `ale`.
- R5: With page mode armed, a short (hit) cycle raises `done` in the 4th clock after the request is accepted, and a long (miss) cycle raises it in the 8th clock.
- R6: Page mode becomes armed only when a configuration write with size field 2'b10 and enable 1 finds the size field already holding 2'b10 from an earlier write. Writing both in the same write leaves page mode off. A write with enable 0 or any other size disarms it.
- R7: A fetch is a long cycle when page mode is off, when no page has been opened since arming, or when address bits 15:8 differ from the open page. Each long cycle opens the page of its address.
- R8: A request with `req_stall` high runs a bus cycle with `psen` never high and ends with `done` and `done_nodata` both high.
- R9: A stall whose address crosses into a new page runs as a long cycle and opens that page, so a following fetch in that page is a short cycle.
- R10: An arming write made while `int_exec` is low leaves page mode off.
- R11: After reset, `req_ready` is high, `ale`, `psen` and `done` are low, page mode is off and no page is open.
- R12: `req_ready` is high in the final clock of a cycle, so a request presented then starts its cycle on the next clock with no idle clock in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_size | input | 2 | Page-size field value to write |
| cfg_en | input | 1 | Page-enable bit value to write |
| int_exec | input | 1 | Core is executing from internal code memory |
| req_valid | input | 1 | Request valid |
| req_stall | input | 1 | Request is a stall (dummy) cycle |
| req_addr | input | 16 | Fetch address |
| req_ready | output | 1 | Controller can accept a request |
| done | output | 1 | Cycle completes this clock |
| done_nodata | output | 1 | Completed cycle was a stall |
| done_data | output | 8 | Fetched byte |
| bus_addr | output | 8 | Multiplexed external address port |
| bus_data_in | input | 8 | External program data port |
| ale | output | 1 | Address-latch strobe for the high byte |
| psen | output | 1 | Program-store read enable (active high) |

## Verification
The hardest case to reach from the ports is a stall that lands exactly on a page crossing, because it is a miss cycle that reads nothing and still has to open the page. The stimulus arms page mode, fetches the last byte of a page as a hit, and issues a stall carrying the first address of the next page. A real fetch at that same address follows, and it must then be a short cycle. The arming order is also exercised: size and enable written together, enable while external code runs, and the correct two-step sequence.

// File: rtl/pgfetch_ctrl.sv
module pgfetch_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [1:0]  cfg_size,
  input  logic        cfg_en,
  input  logic        int_exec,
  input  logic        req_valid,
  input  logic        req_stall,
  input  logic [15:0] req_addr,
  output logic        req_ready,
  output logic        done,
  output logic        done_nodata,
  output logic [7:0]  done_data,
  output logic [7:0]  bus_addr,
  input  logic [7:0]  bus_data_in,
  output logic        ale,
  output logic        psen
);
  localparam logic [1:0] SIZE_FOUR = 2'b10;

  logic [1:0] size_q;
  logic       en_q;
  logic [7:0] page_q;
  logic       page_vld;
  logic       busy;
  logic [2:0] cnt;
  logic       miss_q;
  logic       stall_q;
  logic [7:0] hi_q;
  logic [7:0] lo_q;

  logic last, accept, hit_now, cfg_off;

  assign last    = busy && (cnt == (miss_q ? 3'd7 : 3'd3));
  assign req_ready = !busy || last;
  assign accept  = req_valid && req_ready;
  assign hit_now = en_q && page_vld && (req_addr[15:8] == page_q);
  assign cfg_off = cfg_wr && (!cfg_en || cfg_size != SIZE_FOUR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_q <= 2'b00;
      en_q   <= 1'b0;
    end else if (cfg_wr) begin
      size_q <= cfg_size;
      if (cfg_off)
        en_q <= 1'b0;
      else if (size_q == SIZE_FOUR && int_exec)
        en_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q   <= 8'h00;
      page_vld <= 1'b0;
    end else begin
      if (accept && en_q && !hit_now) begin
        page_q   <= req_addr[15:8];
        page_vld <= 1'b1;
      end
      if (cfg_off)
        page_vld <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= 3'd0;
      miss_q  <= 1'b0;
      stall_q <= 1'b0;
      hi_q    <= 8'h00;
      lo_q    <= 8'h00;
    end else if (accept) begin
      busy    <= 1'b1;
      cnt     <= 3'd0;
      miss_q  <= !hit_now;
      stall_q <= req_stall;
      hi_q    <= req_addr[15:8];
      lo_q    <= req_addr[7:0];
    end else if (last) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt + 3'd1;
    end
  end

  logic in_latch;
  logic [2:0] fcnt;
  assign in_latch = miss_q && (cnt < 3'd4);
  assign fcnt     = miss_q ? cnt - 3'd4 : cnt;

  assign bus_addr    = !busy ? 8'h00 : (in_latch ? hi_q : lo_q);
  assign ale         = busy && in_latch && (cnt == 3'd1 || cnt == 3'd2);
  assign psen        = busy && !stall_q && !in_latch && (fcnt != 3'd0);
  assign done        = last;
  assign done_nodata = last && stall_q;
  assign done_data   = (last && !stall_q) ? bus_data_in : 8'h00;

  assert_ale_miss_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> miss_q && busy);
  assert_ale_high_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> bus_addr == hi_q);
  assert_psen_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    psen |-> !ale && !stall_q && bus_addr == lo_q);
  assert_armed_size_R6: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> size_q == SIZE_FOUR);
  assert_stall_nodata_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_nodata |-> done && !psen);
  assert_accept_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy && cnt == 3'd0);
  assert_open_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && en_q && !cfg_off) |=> page_vld && page_q == hi_q);
endmodule

// File: tb/sim_pgfetch_ctrl.sv
module sim_pgfetch_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [1:0] cfg_size = 2'b00;
  logic cfg_en = 1'b0;
  logic int_exec = 1'b1;
  logic req_valid = 1'b0;
  logic req_stall = 1'b0;
  logic [15:0] req_addr = 16'h0000;
  logic req_ready, done, done_nodata, ale, psen;
  logic [7:0] done_data, bus_addr;
  logic [7:0] bus_data_in = 8'h00;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  pgfetch_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_size(cfg_size), .cfg_en(cfg_en),
    .int_exec(int_exec), .req_valid(req_valid), .req_stall(req_stall), .req_addr(req_addr),
    .req_ready(req_ready), .done(done), .done_nodata(done_nodata), .done_data(done_data),
    .bus_addr(bus_addr), .bus_data_in(bus_data_in), .ale(ale), .psen(psen));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sz, input logic en);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_size = sz; cfg_en = en;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic run(input logic [15:0] a, input bit stall, input bit exp_miss, input string tag);
    int len = 0, ale_n = 0, psen_n = 0;
    logic [7:0] first_addr = 8'h00, last_addr = 8'h00, dd = 8'h00, dat;
    bit nd = 1'b0, rdy = 1'b0, seen = 1'b0;
    dat = a[7:0] ^ 8'hA5;
    @(negedge clk);
    bus_data_in = dat; req_addr = a; req_stall = stall; req_valid = 1'b1;
    chk(req_ready, "R12", {tag, " ready before request"}, int'(req_ready), 1);
    @(posedge clk); #1;
    req_valid = 1'b0;
    for (int i = 1; i <= 20 && !seen; i++) begin
      @(negedge clk);
      if (ale) ale_n++;
      if (psen) psen_n++;
      if (i == 1) first_addr = bus_addr;
      if (done) begin
        seen = 1'b1; len = i; nd = done_nodata; dd = done_data;
        last_addr = bus_addr; rdy = req_ready;
      end
    end
    chk(len == (exp_miss ? 8 : 4), "R5", {tag, " cycle length"}, len, exp_miss ? 8 : 4);
    chk(ale_n == (exp_miss ? 2 : 0), "R3", {tag, " ale clocks"}, ale_n, exp_miss ? 2 : 0);
    chk(psen_n == (stall ? 0 : 3), stall ? "R8" : "R4", {tag, " psen clocks"}, psen_n, stall ? 0 : 3);
    chk(first_addr == (exp_miss ? a[15:8] : a[7:0]), "R1", {tag, " first address byte"},
        int'(first_addr), int'(exp_miss ? a[15:8] : a[7:0]));
    chk(last_addr == a[7:0], "R1", {tag, " fetch address byte"}, int'(last_addr), int'(a[7:0]));
    chk(nd == stall, "R8", {tag, " no-data flag"}, int'(nd), int'(stall));
    if (!stall) chk(dd == dat, "R2", {tag, " data byte"}, int'(dd), int'(dat));
    chk(rdy, "R12", {tag, " ready in final clock"}, int'(rdy), 1);
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(req_ready == 1'b1, "R11", "ready after reset", int'(req_ready), 1);
    chk({ale, psen, done} == 3'b000, "R11", "strobes after reset", int'({ale, psen, done}), 0);
    run(16'h1234, 0, 1, "R11 first fetch");
  endtask

  task automatic test_disabled();
    run(16'h1235, 0, 1, "R7 disabled same page");
  endtask

  task automatic test_arm_order();
    cfg(2'b10, 1'b1);
    run(16'h1236, 0, 1, "R6 size and enable together");
    cfg(2'b10, 1'b1);
    run(16'h1237, 0, 1, "R7 first after arming");
    run(16'h1238, 0, 0, "R5 hit");
    run(16'h2200, 0, 1, "R7 page change");
    run(16'h22FF, 0, 0, "R5 hit end of page");
  endtask

  task automatic test_stalls();
    run(16'h2210, 1, 0, "R8 stall hit");
    run(16'h22FF, 0, 0, "R9 last byte of page");
    run(16'h2300, 1, 1, "R9 stall crossing");
    run(16'h2300, 0, 0, "R9 fetch after stall");
  endtask

  task automatic test_back_to_back();
    int n = 0, ale_n = 0;
    bit seen = 1'b0;
    @(negedge clk);
    req_addr = 16'h2305; req_stall = 1'b0; req_valid = 1'b1;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    chk(req_ready, "R12", "ready on final clock", int'(req_ready), 1);
    req_addr = 16'h2306;
    @(posedge clk); #1;
    req_valid = 1'b0;
    seen = 1'b0;
    for (int i = 1; i <= 20 && !seen; i++) begin
      @(negedge clk);
      if (ale) ale_n++;
      if (done) begin seen = 1'b1; n = i; end
    end
    chk(n == 4, "R12", "back-to-back cycle length", n, 4);
    chk(ale_n == 0, "R12", "back-to-back ale", ale_n, 0);
  endtask

  task automatic test_external_exec();
    cfg(2'b10, 1'b0);
    int_exec = 1'b0;
    cfg(2'b10, 1'b1);
    run(16'h2301, 0, 1, "R10 arming ignored");
    run(16'h2302, 0, 1, "R10 still off");
    int_exec = 1'b1;
    cfg(2'b10, 1'b1);
    run(16'h2303, 0, 1, "R10 armed internally");
    run(16'h2304, 0, 0, "R10 hit");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    test_reset();
    test_disabled();
    test_arm_order();
    test_stalls();
    test_back_to_back();
    test_external_exec();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule